// File: doc/BRIEF.md
# Masked-Write Reset Line Controller

This block is a memory-mapped bank of reset lines for peripheral blocks. The lines are active high and packed sixteen to a 32-bit register. The number of registers is a parameter, and the default of ten registers gives 160 lines. Every write carries its own per-bit write enables in the upper half-word. Software can therefore assert some lines and release others in one access, and it never needs a read-modify-write sequence. Access is through a simple register bus with single-cycle reads: an address, a write strobe, write data and read data. A read returns the present state of the addressed lines.

Line 0 has a second role as the whole-system restart control. When that line goes from asserted to released, the block raises a one-cycle restart request output. Every reset output and the restart request come straight from flip-flops, so no bus input has a combinational path to them.

Top module: `rstctl_top`

## Requirements
- R1: Line k is held in the register at byte address 4*(k/16), in bit position k mod 16. Bits 15:0 of each register hold its 16 lines.
- R2: A write whose data bit 16+n is 1 loads data bit n into line n of the addressed register. A 1 asserts the line and a 0 releases it. The new value appears on the reset outputs starting in the cycle after the clock edge that accepts the write.
- R3: A line whose mask bit (16+n) is 0 in a write keeps its value. A write whose mask bits 31:16 are all zero leaves the register unchanged, whatever bits 15:0 hold.
- R4: One write can move two lines of the same register in opposite directions, asserting one and releasing the other, and each line takes the value given for it.
- R5: A read returns the present line states in bits 15:0, where 1 means asserted. Bits 31:16 always read as 0.
- R6: Some accesses are treated as outside the register space: a register index (address bits above 1:0) at or beyond the register count, or address bits 1:0 that are not zero. A write to such an address changes no line, and a read from it returns 0.
- R7: After power-on reset, every line is in the state chosen by the INIT_ASSERTED parameter (default 0, all released). The restart request is low.
- R8: A transition of line 0 from asserted to released drives the restart request high for exactly one cycle. The pulse starts one cycle after line 0 shows released. Asserting line 0, or releasing it when it is already released, gives no pulse.
- R9: While the write strobe is low, no line changes, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data: 31:16 per-bit write enables, 15:0 line values |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| rst_lines_o | output | NUM_REGS*16 | Reset lines, active high |
| sys_restart_o | output | 1 | One-cycle whole-system restart request |

## Verification
The bench walks a single asserted line across every bit of every register and then releases it. A design with a wrong index or bit mapping shows the line on the wrong output, and a read returns it in the wrong place.

An all-zero-mask write that carries a full data pattern is aimed at a design that ignores the mask: such a design would overwrite the register. A single write that asserts one line and releases another in the same register is aimed at a design that applies one direction to every enabled bit.

Out-of-range and misaligned addresses are aimed at a design that folds them onto real registers. Such a design would alter live lines or return non-zero read data.

The restart checks pin the pulse to the release edge of line 0. A design that fires on assertion, fires on a repeated release, or holds the request for more than one cycle fails these checks.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
    localparam int LINES_PER_REG = 16;
    localparam int BUS_W         = 32;
    typedef logic [LINES_PER_REG-1:0] line_word_t;
endpackage

// File: rtl/rstctl_bank.sv
module rstctl_bank
    import rstctl_pkg::*;
#(
    parameter bit INIT_ASSERTED = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_hit_i,
    input  line_word_t wr_mask_i,
    input  line_word_t wr_val_i,
    output line_word_t lines_o
);
    typedef struct packed {
        line_word_t lines;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i) begin
            st_d.lines = (st_q.lines & ~wr_mask_i) | (wr_val_i & wr_mask_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lines <= {LINES_PER_REG{INIT_ASSERTED}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lines_o = st_q.lines;

    // A write that enables no bit must not disturb the word (R3, R9)
    assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_hit_i || (wr_mask_i == '0)) |=> $stable(lines_o));

    for (genvar n = 0; n < LINES_PER_REG; n++) begin : g_bit_chk
        // Enabled bit takes the written value (R2, R4)
        assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_hit_i && wr_mask_i[n]) |=> (lines_o[n] == $past(wr_val_i[n])));
        // Unenabled bit holds (R3)
        assert_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(wr_hit_i && wr_mask_i[n]) |=> $stable(lines_o[n]));
    end
endmodule

// File: rtl/rstctl_restart.sv
module rstctl_restart #(
    parameter bit INIT_ASSERTED = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line0_i,
    output logic restart_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = line0_i;
        st_d.pulse = st_q.prev & ~line0_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev  <= INIT_ASSERTED;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart_o = st_q.pulse;

    assert_pulse_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_o |=> !restart_o);
    assert_pulse_line_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_o |-> !line0_i);
    assert_release_fires_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(line0_i) |=> restart_o);
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int NUM_REGS      = 10,
    parameter int ADDR_W        = 8,
    parameter bit INIT_ASSERTED = 1'b0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic                          bus_we_i,
    input  logic [BUS_W-1:0]              bus_wdata_i,
    output logic [BUS_W-1:0]              bus_rdata_o,
    output logic [NUM_REGS*LINES_PER_REG-1:0] rst_lines_o,
    output logic                          sys_restart_o
);
    localparam int IDX_W = ADDR_W - 2;

    initial begin
        assert_space_fits_R1: assert (NUM_REGS >= 1 && NUM_REGS <= (1 << IDX_W));
    end

    logic [IDX_W-1:0] reg_idx;
    logic             aligned;
    line_word_t       wmask;
    line_word_t       wval;
    line_word_t       bank_lines [NUM_REGS];
    line_word_t       rd_word;
    logic             rd_valid;

    assign reg_idx = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wmask   = bus_wdata_i[BUS_W-1:LINES_PER_REG];
    assign wval    = bus_wdata_i[LINES_PER_REG-1:0];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
        logic hit;
        assign hit = bus_we_i && aligned && (reg_idx == IDX_W'(i));

        rstctl_bank #(
            .INIT_ASSERTED(INIT_ASSERTED)
        ) bank_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .wr_hit_i (hit),
            .wr_mask_i(wmask),
            .wr_val_i (wval),
            .lines_o  (bank_lines[i])
        );

        assign rst_lines_o[i*LINES_PER_REG +: LINES_PER_REG] = bank_lines[i];
    end

    always_comb begin
        rd_word  = '0;
        rd_valid = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (aligned && (reg_idx == IDX_W'(i))) begin
                rd_word  = bank_lines[i];
                rd_valid = 1'b1;
            end
        end
    end

    assign bus_rdata_o = rd_valid ? {{(BUS_W-LINES_PER_REG){1'b0}}, rd_word} : '0;

    rstctl_restart #(
        .INIT_ASSERTED(INIT_ASSERTED)
    ) restart_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .line0_i  (rst_lines_o[0]),
        .restart_o(sys_restart_o)
    );

    assert_outside_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && ((int'(bus_addr_i[ADDR_W-1:2]) >= NUM_REGS) || (bus_addr_i[1:0] != 2'b00)))
        |=> $stable(rst_lines_o));
    assert_no_strobe_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_we_i |=> $stable(rst_lines_o));
    assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[BUS_W-1:LINES_PER_REG] == '0);
endmodule

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 3;
    localparam int AW    = 6;
    localparam int NLINE = NREG * 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             we = 1'b0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NLINE-1:0] lines;
    logic             restart;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl [NREG];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstctl_top #(.NUM_REGS(NREG), .ADDR_W(AW), .INIT_ASSERTED(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rst_lines_o(lines),
        .sys_restart_o(restart)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NLINE-1:0] model_vec();
        logic [NLINE-1:0] v;
        for (int r = 0; r < NREG; r++) v[r*16 +: 16] = mdl[r];
        return v;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a[1:0] == 2'b00 && int'(a[AW-1:2]) < NREG)
            mdl[a[AW-1:2]] = (mdl[a[AW-1:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        chk(rdata == exp, tag, 64'(rdata), 64'(exp));
    endtask

    task automatic lines_chk(input string tag);
        chk(lines == model_vec(), tag, 64'(lines), 64'(model_vec()));
    endtask

    task automatic next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        lines_chk("R7 lines after reset");
        chk(restart == 1'b0, "R7 restart after reset", 64'(restart), 64'd0);
        for (int r = 0; r < NREG; r++) rd_chk(AW'(r*4), 32'h0, "R7 read after reset");

        // R1, R2, R5: walk one line over every bit
        for (int r = 0; r < NREG; r++) begin
            for (int b = 0; b < 16; b++) begin
                wr(AW'(r*4), (32'h1 << (16+b)) | (32'h1 << b));
                chk(lines[r*16+b] == 1'b1, "R1 walked line asserted", 64'(lines), 64'(model_vec()));
                lines_chk("R2 assert single line");
                rd_chk(AW'(r*4), 32'(1 << b), "R5 readback single line");
                wr(AW'(r*4), 32'h1 << (16+b));
                lines_chk("R2 release single line");
            end
        end

        // R3: all-zero mask leaves register unchanged
        wr(AW'(4), 32'hFFFF_A5A5);
        wr(AW'(4), 32'h0000_5A5A);
        lines_chk("R3 zero mask keeps lines");
        rd_chk(AW'(4), 32'h0000_A5A5, "R3 zero mask readback");
        wr(AW'(4), 32'h00F0_FFFF);
        rd_chk(AW'(4), 32'h0000_A5F5, "R3 partial mask readback");

        // R4: opposite directions in one write
        wr(AW'(8), 32'h0008_0008);
        wr(AW'(8), 32'h0208_0200);
        chk(lines[2*16+9] == 1'b1 && lines[2*16+3] == 1'b0, "R4 opposite directions",
            64'(lines[47:32]), 64'(mdl[2]));
        rd_chk(AW'(8), {16'h0, mdl[2]}, "R4 readback");

        // R2, R3, R5: pseudo-random masked writes
        for (int t = 0; t < 200; t++) begin
            next_rand();
            wr(AW'((seed[9:8] % NREG) * 4), seed);
            lines_chk("R2 random masked write");
            rd_chk(AW'((seed[9:8] % NREG) * 4), {16'h0, mdl[seed[9:8] % NREG]}, "R5 random readback");
        end

        // R6: out-of-range and misaligned accesses
        for (int i = NREG; i < 16; i++) begin
            wr(AW'(i*4), 32'hFFFF_FFFF);
            lines_chk("R6 out-of-range write ignored");
            rd_chk(AW'(i*4), 32'h0, "R6 out-of-range read zero");
        end
        for (int r = 0; r < NREG; r++) begin
            for (int o = 1; o < 4; o++) begin
                wr(AW'(r*4+o), 32'hFFFF_0000 | {16'h0, ~mdl[r]});
                lines_chk("R6 misaligned write ignored");
                rd_chk(AW'(r*4+o), 32'h0, "R6 misaligned read zero");
            end
        end

        // R9: strobe low has no effect
        @(negedge clk);
        addr = AW'(0); wdata = 32'hFFFF_FFFF; we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lines_chk("R9 no strobe no change");

        // R8: restart pulse
        wr(AW'(0), 32'h0001_0000);
        @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk(restart == 1'b0, "R8 no pulse when idle", 64'(restart), 64'd0);
        end
        wr(AW'(0), 32'h0001_0000);
        chk(restart == 1'b0, "R8 re-release no pulse", 64'(restart), 64'd0);
        @(negedge clk);
        chk(restart == 1'b0, "R8 re-release no pulse later", 64'(restart), 64'd0);
        wr(AW'(0), 32'h0001_0001);
        chk(restart == 1'b0, "R8 assert no pulse", 64'(restart), 64'd0);
        @(negedge clk);
        chk(restart == 1'b0, "R8 assert no pulse later", 64'(restart), 64'd0);
        wr(AW'(0), 32'h8001_8000);
        chk(restart == 1'b0, "R8 pulse not yet", 64'(restart), 64'd0);
        lines_chk("R8 release with other bit");
        @(negedge clk);
        chk(restart == 1'b1, "R8 pulse high", 64'(restart), 64'd1);
        @(negedge clk);
        chk(restart == 1'b0, "R8 pulse one cycle", 64'(restart), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule